// File: doc/BRIEF.md
# Indirect Index Pattern Learner

This block watches a stream of index loads and cache misses and works out whether a miss address is formed as `base + (index scaled by a power of two)`. An index event arrives tagged with the identifier of the table entry that produced it. The first index event for an identifier opens a learning entry and makes it the one that receives misses. Each miss in this first phase is turned into one base-address candidate per configured shift, `miss - (index << s)`, and stored. A negative shift is an arithmetic right shift.

A later index event with the same identifier supplies a second index and starts the second phase. Each following miss is turned into second-round candidates with that index. Each one is compared with the stored candidates for the same shift. The first agreement produces a one-cycle report carrying the identifier, the base address and the shift. The entry is then released. If the second phase sees as many misses as the candidate capacity without any agreement, the entry is released without a report. Only one entry receives misses at a time. Storage for the other entries is kept, so learning for one identifier can be interleaved with another.

Top module: `idx_pattern_learner`

## Requirements
- R1: After reset no report is raised, and misses are ignored until an index event has arrived.
- R2: A first-phase miss stores `miss - (idx1 << s)` for every configured shift s. A second-phase miss whose `miss - (idx2 << s)` equals a stored candidate for the same s raises `hit_valid_o` for exactly one cycle, on the edge after the miss. The report carries the identifier, that base and s.
- R3: A negative entry `-k` in the shift list is an arithmetic right shift by k, so the candidate is `miss - (idx >>> k)`. The reported shift is the signed value `-k`.
- R4: When several shifts agree on the same miss, the shift that stands earliest in the shift list is reported, with its base.
- R5: An entry stores at most MISSES first-phase misses. Further first-phase misses are ignored until its second index arrives.
- R6: When MISSES second-phase misses pass with no agreement, the entry is released and miss tracking stops. A run of MISSES-1 non-agreeing misses followed by an agreeing one still reports.
- R7: After a report, the entry is released and miss tracking stops, so a repeat of the agreeing miss raises no report.
- R8: An index event for an identifier whose entry already holds a second index restarts that entry. The new value becomes its first index and the stored candidates are discarded.
- R9: Every index event moves miss tracking to the entry it addressed. An entry that is no longer tracked keeps its first-phase candidates, and they are matched once its second index arrives.
- R10: When an index event and a miss arrive in the same cycle, the index event is taken and the miss is dropped.
- R11: A new identifier takes the lowest free entry. When no entry is free, entries are replaced in round-robin order starting at entry 0, so the oldest identifier loses its history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_valid_i | input | 1 | Index event strobe |
| idx_owner_i | input | OWNER_W | Identifier of the table entry that issued the index |
| idx_value_i | input | IDX_W | Signed index value |
| miss_valid_i | input | 1 | Cache miss strobe |
| miss_addr_i | input | ADDR_W | Miss address |
| hit_valid_o | output | 1 | One-cycle pattern report |
| hit_owner_o | output | OWNER_W | Identifier the pattern belongs to |
| hit_base_o | output | ADDR_W | Learned base address |
| hit_shift_o | output | 8 | Learned shift, signed, negative means right shift |

## Verification
The assertions take for granted that the strobes and their payloads are known whenever a strobe is high. They also assume that an index event may coincide with a miss, with the index event taking priority. The stimulus drives every input on the falling edge and holds each strobe for a single cycle. It picks bases and unrelated "junk" miss addresses far enough apart that no shift gives an accidental agreement. The only agreements are the ones a scenario intends, and each expected base and shift is worked out by hand from the candidate formula.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  typedef logic signed [7:0] shift_t;

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ipl_cand_gen.sv
module ipl_cand_gen #(
  parameter int NUM_SHIFTS = 4,
  parameter int SHIFT_LIST [NUM_SHIFTS] = '{2, 3, 4, -3},
  parameter int ADDR_W = 32,
  parameter int IDX_W = 16
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic signed [IDX_W-1:0] index_i,
  output logic [ADDR_W-1:0]       cand_o [NUM_SHIFTS]
);
  logic signed [ADDR_W-1:0] ext;
  assign ext = ADDR_W'(index_i);

  for (genvar g = 0; g < NUM_SHIFTS; g++) begin : g_shift
    localparam int SH = SHIFT_LIST[g];
    logic signed [ADDR_W-1:0] scaled;
    if (SH >= 0) begin : g_left
      assign scaled = ext <<< SH;
    end else begin : g_right
      assign scaled = ext >>> (-SH);
    end
    assign cand_o[g] = addr_i - scaled;
  end
endmodule

// File: rtl/ipl_lookup.sv
module ipl_lookup #(
  parameter int ENTRIES = 4,
  parameter int OWNER_W = 4,
  localparam int PTR_W = ipl_pkg::width_of(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [OWNER_W-1:0] owner_i [ENTRIES],
  input  logic [OWNER_W-1:0] query_i,
  output logic               hit_o,
  output logic [PTR_W-1:0]   hit_idx_o,
  output logic               free_o,
  output logic [PTR_W-1:0]   free_idx_o
);
  always_comb begin
    hit_o      = 1'b0;
    hit_idx_o  = '0;
    free_o     = 1'b0;
    free_idx_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!hit_o && valid_i[e] && owner_i[e] == query_i) begin
        hit_o     = 1'b1;
        hit_idx_o = PTR_W'(e);
      end
      if (!free_o && !valid_i[e]) begin
        free_o     = 1'b1;
        free_idx_o = PTR_W'(e);
      end
    end
  end
endmodule

// File: rtl/ipl_match.sv
module ipl_match #(
  parameter int MISSES = 4,
  parameter int NUM_SHIFTS = 4,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(MISSES + 1),
  localparam int SEL_W = ipl_pkg::width_of(NUM_SHIFTS)
) (
  input  logic [ADDR_W-1:0] cand_i  [NUM_SHIFTS],
  input  logic [ADDR_W-1:0] store_i [MISSES][NUM_SHIFTS],
  input  logic [CNT_W-1:0]  count_i,
  output logic              found_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] base_o
);
  // Outer loop over shifts: earliest list position wins (R4)
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    base_o  = '0;
    for (int s = 0; s < NUM_SHIFTS; s++) begin
      for (int m = 0; m < MISSES; m++) begin
        if (!found_o && CNT_W'(m) < count_i && store_i[m][s] == cand_i[s]) begin
          found_o = 1'b1;
          sel_o   = SEL_W'(s);
          base_o  = cand_i[s];
        end
      end
    end
  end
endmodule

// File: rtl/idx_pattern_learner.sv
module idx_pattern_learner #(
  parameter int ENTRIES = 4,
  parameter int MISSES = 4,
  parameter int NUM_SHIFTS = 4,
  parameter int SHIFT_LIST [NUM_SHIFTS] = '{2, 3, 4, -3},
  parameter int ADDR_W = 32,
  parameter int IDX_W = 16,
  parameter int OWNER_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       idx_valid_i,
  input  logic [OWNER_W-1:0]         idx_owner_i,
  input  logic signed [IDX_W-1:0]    idx_value_i,
  input  logic                       miss_valid_i,
  input  logic [ADDR_W-1:0]          miss_addr_i,
  output logic                       hit_valid_o,
  output logic [OWNER_W-1:0]         hit_owner_o,
  output logic [ADDR_W-1:0]          hit_base_o,
  output logic signed [7:0]          hit_shift_o
);
  import ipl_pkg::*;

  localparam int PTR_W  = width_of(ENTRIES);
  localparam int CNT_W  = $clog2(MISSES + 1);
  localparam int SLOT_W = width_of(MISSES);
  localparam int SEL_W  = width_of(NUM_SHIFTS);

  // Entry state
  logic [ENTRIES-1:0]      ent_valid_q;
  logic [OWNER_W-1:0]      ent_owner_q [ENTRIES];
  logic signed [IDX_W-1:0] ent_idx1_q  [ENTRIES];
  logic signed [IDX_W-1:0] ent_idx2_q  [ENTRIES];
  logic [ENTRIES-1:0]      ent_has2_q;
  logic [CNT_W-1:0]        ent_cnt_q   [ENTRIES];
  logic [ADDR_W-1:0]       cand_q      [ENTRIES][MISSES][NUM_SHIFTS];

  // Tracking pointer and replacement pointer
  logic             trk_active_q, trk_active_d;
  logic [PTR_W-1:0] trk_ptr_q, trk_ptr_d;
  logic [CNT_W-1:0] p2cnt_q, p2cnt_d;
  logic [PTR_W-1:0] rr_q, rr_d;

  // Report registers
  logic              hit_valid_q;
  logic [OWNER_W-1:0] hit_owner_q;
  logic [ADDR_W-1:0] hit_base_q;
  shift_t            hit_shift_q;

  // Lookup
  logic             lk_hit, lk_free;
  logic [PTR_W-1:0] lk_idx, lk_free_idx;

  ipl_lookup #(.ENTRIES(ENTRIES), .OWNER_W(OWNER_W)) u_lookup (
    .valid_i    (ent_valid_q),
    .owner_i    (ent_owner_q),
    .query_i    (idx_owner_i),
    .hit_o      (lk_hit),
    .hit_idx_o  (lk_idx),
    .free_o     (lk_free),
    .free_idx_o (lk_free_idx)
  );

  // Candidate generation for the tracked entry
  logic                    cur_phase2;
  logic signed [IDX_W-1:0] cur_index;
  logic [ADDR_W-1:0]       gen_cand [NUM_SHIFTS];
  logic [ADDR_W-1:0]       cur_store [MISSES][NUM_SHIFTS];

  assign cur_phase2 = ent_has2_q[trk_ptr_q];
  assign cur_index  = cur_phase2 ? ent_idx2_q[trk_ptr_q] : ent_idx1_q[trk_ptr_q];

  always_comb begin
    for (int m = 0; m < MISSES; m++) begin
      for (int s = 0; s < NUM_SHIFTS; s++) begin
        cur_store[m][s] = cand_q[trk_ptr_q][m][s];
      end
    end
  end

  ipl_cand_gen #(
    .NUM_SHIFTS(NUM_SHIFTS), .SHIFT_LIST(SHIFT_LIST),
    .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_cand_gen (
    .addr_i  (miss_addr_i),
    .index_i (cur_index),
    .cand_o  (gen_cand)
  );

  logic              mt_found;
  logic [SEL_W-1:0]  mt_sel;
  logic [ADDR_W-1:0] mt_base;

  ipl_match #(.MISSES(MISSES), .NUM_SHIFTS(NUM_SHIFTS), .ADDR_W(ADDR_W)) u_match (
    .cand_i  (gen_cand),
    .store_i (cur_store),
    .count_i (ent_cnt_q[trk_ptr_q]),
    .found_o (mt_found),
    .sel_o   (mt_sel),
    .base_o  (mt_base)
  );

  // Control decode
  logic             idx_to_second, alloc_en, rr_adv;
  logic [PTR_W-1:0] alloc_ptr;
  logic             miss_go, rec_en, chk_en, hit_en, exhaust, free_en;
  shift_t           sel_shift;

  always_comb begin
    idx_to_second = idx_valid_i && lk_hit && !ent_has2_q[lk_idx];
    alloc_en      = idx_valid_i && !idx_to_second;
    alloc_ptr     = lk_hit ? lk_idx : (lk_free ? lk_free_idx : rr_q);
    rr_adv        = alloc_en && !lk_hit && !lk_free;

    miss_go = miss_valid_i && !idx_valid_i && trk_active_q;        // R10
    rec_en  = miss_go && !cur_phase2 && (ent_cnt_q[trk_ptr_q] < CNT_W'(MISSES)); // R5
    chk_en  = miss_go && cur_phase2;
    hit_en  = chk_en && mt_found;
    exhaust = chk_en && !mt_found && (p2cnt_q == CNT_W'(MISSES - 1));
    free_en = hit_en || exhaust;

    sel_shift = '0;
    for (int s = 0; s < NUM_SHIFTS; s++) begin
      if (mt_sel == SEL_W'(s)) sel_shift = shift_t'(SHIFT_LIST[s]);
    end
  end

  // Tracking next state
  always_comb begin
    trk_active_d = trk_active_q;
    trk_ptr_d    = trk_ptr_q;
    p2cnt_d      = p2cnt_q;
    rr_d         = rr_adv ? ((rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1) : rr_q;
    if (idx_valid_i) begin
      trk_active_d = 1'b1;
      trk_ptr_d    = idx_to_second ? lk_idx : alloc_ptr;
      p2cnt_d      = '0;
    end else if (free_en) begin
      trk_active_d = 1'b0;
      p2cnt_d      = '0;
    end else if (chk_en) begin
      p2cnt_d = p2cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_active_q <= 1'b0;
      trk_ptr_q    <= '0;
      p2cnt_q      <= '0;
      rr_q         <= '0;
    end else begin
      trk_active_q <= trk_active_d;
      trk_ptr_q    <= trk_ptr_d;
      p2cnt_q      <= p2cnt_d;
      rr_q         <= rr_d;
    end
  end

  // Entry registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid_q <= '0;
      ent_has2_q  <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        ent_owner_q[e] <= '0;
        ent_idx1_q[e]  <= '0;
        ent_idx2_q[e]  <= '0;
        ent_cnt_q[e]   <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (alloc_en && alloc_ptr == PTR_W'(e)) begin
          ent_valid_q[e] <= 1'b1;
          ent_owner_q[e] <= idx_owner_i;
          ent_idx1_q[e]  <= idx_value_i;
          ent_idx2_q[e]  <= '0;
          ent_has2_q[e]  <= 1'b0;
          ent_cnt_q[e]   <= '0;
        end else if (idx_to_second && lk_idx == PTR_W'(e)) begin
          ent_idx2_q[e] <= idx_value_i;
          ent_has2_q[e] <= 1'b1;
        end else if (free_en && trk_ptr_q == PTR_W'(e)) begin
          ent_valid_q[e] <= 1'b0;
          ent_owner_q[e] <= '0;
          ent_idx1_q[e]  <= '0;
          ent_idx2_q[e]  <= '0;
          ent_has2_q[e]  <= 1'b0;
          ent_cnt_q[e]   <= '0;
        end else if (rec_en && trk_ptr_q == PTR_W'(e)) begin
          ent_cnt_q[e] <= ent_cnt_q[e] + 1'b1;
        end
      end
    end
  end

  // Candidate storage: datapath, no reset, guarded by the count
  always_ff @(posedge clk) begin
    if (rec_en) begin
      for (int s = 0; s < NUM_SHIFTS; s++) begin
        cand_q[trk_ptr_q][ent_cnt_q[trk_ptr_q][SLOT_W-1:0]][s] <= gen_cand[s];
      end
    end
  end

  // Report
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid_q <= 1'b0;
      hit_owner_q <= '0;
      hit_base_q  <= '0;
      hit_shift_q <= '0;
    end else begin
      hit_valid_q <= hit_en;
      if (hit_en) begin
        hit_owner_q <= ent_owner_q[trk_ptr_q];
        hit_base_q  <= mt_base;
        hit_shift_q <= sel_shift;
      end
    end
  end

  assign hit_valid_o = hit_valid_q;
  assign hit_owner_o = hit_owner_q;
  assign hit_base_o  = hit_base_q;
  assign hit_shift_o = hit_shift_q;

  // Assertions
  p_report_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid_o |-> $past(miss_valid_i && !idx_valid_i && trk_active_q));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid_o |=> !hit_valid_o);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid_o |-> !trk_active_q || $past(idx_valid_i));

  p_index_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid_i && miss_valid_i) |=> !hit_valid_o);

  p_index_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid_i |=> trk_active_q);

  p_exhaust_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !mt_found && p2cnt_q == CNT_W'(MISSES - 1)) |=> !trk_active_q || $past(idx_valid_i));

  p_idle_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_active_q |=> !hit_valid_o);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
    p_cnt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ent_cnt_q[e] <= CNT_W'(MISSES));
  end
endmodule

// File: tb/idx_pattern_learner_bench.sv
module idx_pattern_learner_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        idx_valid;
  logic [3:0]  idx_owner;
  logic signed [15:0] idx_value;
  logic        miss_valid;
  logic [31:0] miss_addr;
  logic        hit_valid;
  logic [3:0]  hit_owner;
  logic [31:0] hit_base;
  logic signed [7:0] hit_shift;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  idx_pattern_learner u_idx_pattern_learner (
    .clk(clk), .rst_n(rst_n),
    .idx_valid_i(idx_valid), .idx_owner_i(idx_owner), .idx_value_i(idx_value),
    .miss_valid_i(miss_valid), .miss_addr_i(miss_addr),
    .hit_valid_o(hit_valid), .hit_owner_o(hit_owner),
    .hit_base_o(hit_base), .hit_shift_o(hit_shift)
  );

  function automatic logic [31:0] base_of(input logic [31:0] miss, input int idx, input int sh);
    if (sh >= 0) return miss - 32'(idx <<< sh);
    return miss - 32'(idx >>> (-sh));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; idx_valid = 0; miss_valid = 0;
    idx_owner = '0; idx_value = '0; miss_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_idx(input logic [3:0] owner, input int val);
    @(negedge clk);
    idx_valid = 1; idx_owner = owner; idx_value = 16'(val);
    @(posedge clk); #1;
    idx_valid = 0;
  endtask

  // Drives one miss; returns with outputs sampled after the edge that took it
  task automatic send_miss(input logic [31:0] addr);
    @(negedge clk);
    miss_valid = 1; miss_addr = addr;
    @(posedge clk); #1;
    miss_valid = 0;
  endtask

  task automatic expect_none(input string req);
    checks++;
    if (hit_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: hit_valid=%0b expected 0", req, hit_valid);
    end
  endtask

  task automatic expect_hit(input string req, input logic [3:0] own,
                            input logic [31:0] base, input int sh);
    checks++;
    if (hit_valid !== 1'b1 || hit_owner !== own || hit_base !== base || hit_shift !== 8'(sh)) begin
      errors++;
      $display("FAIL %s: valid=%0b owner=%0d base=%h shift=%0d expected valid=1 owner=%0d base=%h shift=%0d",
               req, hit_valid, hit_owner, hit_base, hit_shift, own, base, sh);
    end
  endtask

  task automatic junk(input int n, input logic [31:0] start);
    for (int k = 0; k < n; k++) begin
      send_miss(start + 32'(k) * 32'h100);
      expect_none("junk miss");
    end
  endtask

  // R1
  task automatic t_reset();
    checks++;
    if (hit_valid !== 1'b0 || hit_base !== '0) begin
      errors++;
      $display("FAIL R1: valid=%0b base=%h expected 0 0", hit_valid, hit_base);
    end
    send_miss(32'h1000_0028);
    expect_none("R1 miss before index");
  endtask

  // R2 and R7
  task automatic t_basic();
    send_idx(4'd1, 10);
    send_miss(32'h1000_0000 + (10 << 2));
    expect_none("R2 first phase");
    send_idx(4'd1, 20);
    send_miss(32'h1000_0000 + (20 << 2));
    expect_hit("R2 match", 4'd1, 32'h1000_0000, 2);
    send_miss(32'h1000_0000 + (20 << 2));
    expect_none("R7 released after report");
  endtask

  // R3
  task automatic t_negative();
    send_idx(4'd2, 64);
    send_miss(32'h2000_0008);
    send_idx(4'd2, 128);
    send_miss(32'h2000_0010);
    expect_hit("R3 right shift", 4'd2, base_of(32'h2000_0010, 128, -3), -3);
  endtask

  // R4
  task automatic t_priority();
    logic [31:0] b = 32'h2800_0000;
    send_idx(4'd3, 4);
    send_miss(b + 32);
    send_miss(b + 48);
    send_idx(4'd3, 8);
    send_miss(b + 64);
    expect_hit("R4 earliest shift", 4'd3, b + 32, 2);
  endtask

  // R5
  task automatic t_capacity();
    logic [31:0] b = 32'h3000_0000;
    send_idx(4'd4, 3);
    junk(4, 32'h5000_0000);
    send_miss(b + (3 << 2));
    send_idx(4'd4, 5);
    send_miss(b + (5 << 2));
    expect_none("R5 miss beyond capacity ignored");
  endtask

  // R6
  task automatic t_exhaust();
    logic [31:0] b = 32'h3800_0000;
    send_idx(4'd5, 1);
    send_miss(b + 4);
    send_idx(4'd5, 2);
    junk(4, 32'h6000_0000);
    send_miss(b + 8);
    expect_none("R6 exhausted entry");
    send_idx(4'd6, 1);
    send_miss(b + 4);
    send_idx(4'd6, 2);
    junk(3, 32'h6000_0000);
    send_miss(b + 8);
    expect_hit("R6 last allowed miss", 4'd6, b, 2);
  endtask

  // R8
  task automatic t_restart();
    logic [31:0] b = 32'h4000_0000;
    send_idx(4'd7, 5);
    send_miss(b + (5 << 2));
    send_idx(4'd7, 6);
    send_idx(4'd7, 9);
    send_miss(b + (9 << 3));
    expect_none("R8 restarted entry records");
    send_idx(4'd7, 11);
    send_miss(b + (11 << 3));
    expect_hit("R8 restart learns new index", 4'd7, b, 3);
  endtask

  // R9
  task automatic t_switch();
    logic [31:0] b = 32'h4800_0000;
    send_idx(4'd8, 2);
    send_miss(b + (2 << 4));
    send_idx(4'd9, 100);
    send_miss(32'h7000_0000);
    send_idx(4'd8, 3);
    send_miss(b + (3 << 4));
    expect_hit("R9 resumed entry", 4'd8, b, 4);
  endtask

  // R10
  task automatic t_same_cycle();
    logic [31:0] b = 32'h5800_0000;
    send_idx(4'd10, 1);
    send_miss(b + 4);
    send_idx(4'd10, 2);
    @(negedge clk);
    idx_valid = 1; idx_owner = 4'd11; idx_value = 16'd7;
    miss_valid = 1; miss_addr = b + 8;
    @(posedge clk); #1;
    idx_valid = 0; miss_valid = 0;
    expect_none("R10 index wins");
  endtask

  // R11
  task automatic t_evict();
    logic [31:0] b = 32'h6800_0000;
    do_reset();
    for (int o = 1; o <= 5; o++) send_idx(4'(o), 0);
    send_idx(4'd1, 10);
    send_miss(b + (10 << 2));
    send_idx(4'd1, 20);
    send_miss(b + (20 << 2));
    expect_hit("R11 evicted owner reallocated", 4'd1, b, 2);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idx_valid = 0; miss_valid = 0;
    idx_owner = '0; idx_value = '0; miss_addr = '0;
    do_reset();
    t_reset();
    t_basic();
    t_negative();
    t_priority();
    t_capacity();
    t_exhaust();
    t_restart();
    t_switch();
    t_same_cycle();
    t_evict();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule